// File: doc/BRIEF.md
# Sector-write flash command decoder

This block is the control logic of a byte-wide flash that is rewritten one whole sector at a time, with no erase step. It sits on an SRAM-like bus with an address, an 8-bit write data input, an 8-bit read data output and active-low chip, output and write enables. Writes are gathered into a sector image. A timed write cycle then stores the image into a small register array, and any byte that was not loaded comes out as FFh.

A fixed three-write unlock prefix guards three commands: arm protection and open a load, enter the identification mode, and leave it. Once protection is armed, a write that does not follow the prefix still costs a full write cycle but stores nothing. The bus has a write when ce_n and we_n are low and oe_n is high on a clock edge. It has a read when ce_n and oe_n are low and we_n is high. Sector size, sector count, the load window and the write-cycle length are parameters, and write time is counted in clocks.

Top module: `sector_flash_ctl`

## Requirements
- R1: After reset, busy is low, protection is off, the identification mode is off, and every array byte reads FFh.
- R2: The unlock prefix is AAh written to 5555h, then 55h to 2AAAh, then a command byte written to 5555h. The command bytes are A0h (program), 90h (enter identification) and F0h (leave identification). Writes that form part of a prefix never store data.
- R3: A write that breaks the prefix sends the detector back to idle. This covers a wrong address or data on the second write, a third write away from 5555h, and a command byte that is not one of the three. That write is then handled as an ordinary write.
- R4: When protection is off, an ordinary write opens a sector load holding that byte. The load closes, and busy rises, on the LOAD_TIMEOUT-th clock edge after the edge that captured the last accepted byte.
- R5: When the write cycle completes, each loaded byte reads its last loaded value, and every other byte of that sector reads FFh. Bytes may be loaded in any order and may be loaded again.
- R6: During a load, a write to a sector other than the one the load started in is discarded and does not restart the load window.
- R7: busy stays high for exactly TWC_CYCLES clocks. A read during that time returns BUSY_MARK. A write during that time is ignored and does not open a load.
- R8: Command A0h turns protection on until reset and opens a load window with no byte yet. If no byte arrives, busy rises LOAD_TIMEOUT edges after the command and nothing is stored.
- R9: While protection is on, an ordinary write raises busy at the edge that captures it, holds busy for TWC_CYCLES clocks, and stores nothing.
- R10: Command 90h starts a busy period and enters the identification mode. In that mode, a read of address 0 returns MFR_CODE, a read of address 1 returns DEV_CODE, and a read of any other address returns 00h.
- R11: Command F0h starts a busy period and leaves the identification mode. Array reads then work again.
- R12: The byte offset is the low log2(SECTOR_BYTES) address bits. The sector is the next log2(NUM_SECTORS) bits. Higher address bits are ignored for array access, so the array is mirrored.
- R13: dout_en is high exactly in a read cycle. Outside a read cycle, dout is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 00h when not reading |
| dout_en | output | 1 | High while a read cycle drives dout |
| busy | output | 1 | High for the whole write cycle |

## Verification
A wrong unlock step shows up on the next write. That write either stores data it should not, or raises busy at once where it should open a load. Both can be seen at the next read or on busy within one clock. A wrong sector latch or a wrong valid mask only shows once the cycle ends, as a wrong byte or a missing FFh in a later read of that sector. Miscounted load or busy windows move the rising or falling edge of busy by whole cycles, so the bench measures both edges exactly.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
   localparam logic [15:0] UNLK_A1  = 16'h5555;
   localparam logic [15:0] UNLK_A2  = 16'h2AAA;
   localparam logic [7:0]  KEY1     = 8'hAA;
   localparam logic [7:0]  KEY2     = 8'h55;
   localparam logic [7:0]  OP_PROG  = 8'hA0;
   localparam logic [7:0]  OP_ID_IN = 8'h90;
   localparam logic [7:0]  OP_ID_EX = 8'hF0;

   typedef enum logic [1:0] {ST_NORM, ST_LOAD, ST_BUSY} sfc_state_e;
   typedef enum logic [1:0] {CMD_NONE, CMD_PROG, CMD_ID_ENTER, CMD_ID_EXIT} sfc_cmd_e;
endpackage

// File: rtl/sfc_unlock.sv
`timescale 1ns/1ps
module sfc_unlock import sfc_pkg::*; #(
   parameter int ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic              consumed,
   output sfc_cmd_e          cmd
);
   typedef enum logic [1:0] {U_IDLE, U_GOT1, U_GOT2} ustep_e;

   ustep_e step_q, step_d;
   logic   at_first, at_second;

   assign at_first  = (addr == ADDR_W'(UNLK_A1));
   assign at_second = (addr == ADDR_W'(UNLK_A2));

   always_comb begin
      step_d   = step_q;
      consumed = 1'b0;
      cmd      = CMD_NONE;
      if (wr_en) begin
         step_d = U_IDLE;
         unique case (step_q)
            U_IDLE: if (at_first && din == KEY1) begin
               consumed = 1'b1;
               step_d   = U_GOT1;
            end
            U_GOT1: if (at_second && din == KEY2) begin
               consumed = 1'b1;
               step_d   = U_GOT2;
            end
            U_GOT2: if (at_first) begin
               if (din == OP_PROG)       cmd = CMD_PROG;
               else if (din == OP_ID_IN) cmd = CMD_ID_ENTER;
               else if (din == OP_ID_EX) cmd = CMD_ID_EXIT;
               consumed = (cmd != CMD_NONE);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= U_IDLE;
      else        step_q <= step_d;
   end
endmodule

// File: rtl/sfc_page_buf.sv
`timescale 1ns/1ps
module sfc_page_buf #(
   parameter int SECTOR_BYTES = 8,
   localparam int OFS_W = $clog2(SECTOR_BYTES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      wr_en,
   input  logic [OFS_W-1:0]          ofs,
   input  logic [7:0]                din,
   output logic [SECTOR_BYTES*8-1:0] image
);
   for (genvar i = 0; i < SECTOR_BYTES; i++) begin : g_slot
      logic [7:0] byte_q;
      logic       vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
            vld_q  <= 1'b0;
         end else if (wr_en && ofs == OFS_W'(i)) begin
            byte_q <= din;
            vld_q  <= 1'b1;
         end else if (clear) begin
            vld_q  <= 1'b0;
         end
      end
      assign image[i*8 +: 8] = vld_q ? byte_q : 8'hFF;
   end
endmodule

// File: rtl/sfc_array.sv
`timescale 1ns/1ps
module sfc_array #(
   parameter int SECTOR_BYTES = 8,
   parameter int NUM_SECTORS  = 8,
   localparam int OFS_W = $clog2(SECTOR_BYTES),
   localparam int SEC_W = $clog2(NUM_SECTORS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      commit,
   input  logic [SEC_W-1:0]          commit_sec,
   input  logic [SECTOR_BYTES*8-1:0] image,
   input  logic [SEC_W-1:0]          rd_sec,
   input  logic [OFS_W-1:0]          rd_ofs,
   output logic [7:0]                rd_byte
);
   logic [SECTOR_BYTES*8-1:0] rows [NUM_SECTORS];

   for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_row
      logic [SECTOR_BYTES*8-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   row_q <= '1;
         else if (commit && commit_sec == SEC_W'(s))   row_q <= image;
      end
      assign rows[s] = row_q;
   end

   assign rd_byte = rows[rd_sec][{rd_ofs, 3'b000} +: 8];
endmodule

// File: rtl/sector_flash_ctl.sv
`timescale 1ns/1ps
module sector_flash_ctl import sfc_pkg::*; #(
   parameter int         ADDR_W       = 15,
   parameter int         SECTOR_BYTES = 8,
   parameter int         NUM_SECTORS  = 8,
   parameter int         LOAD_TIMEOUT = 6,
   parameter int         TWC_CYCLES   = 20,
   parameter logic [7:0] MFR_CODE     = 8'h5A,
   parameter logic [7:0] DEV_CODE     = 8'hC3,
   parameter logic [7:0] BUSY_MARK    = 8'hD2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              dout_en,
   output logic              busy
);
   localparam int OFS_W   = $clog2(SECTOR_BYTES);
   localparam int SEC_W   = $clog2(NUM_SECTORS);
   localparam int CNT_MAX = (LOAD_TIMEOUT > TWC_CYCLES) ? LOAD_TIMEOUT : TWC_CYCLES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (ADDR_W < 15 || ADDR_W < OFS_W + SEC_W) begin : g_bad_addr
      $error("ADDR_W too narrow for unlock addresses or array");
   end
   if (SECTOR_BYTES < 2 || (1 << OFS_W) != SECTOR_BYTES) begin : g_bad_sec
      $error("SECTOR_BYTES must be a power of two, at least 2");
   end
   if (NUM_SECTORS < 2 || (1 << SEC_W) != NUM_SECTORS) begin : g_bad_num
      $error("NUM_SECTORS must be a power of two, at least 2");
   end
   if (LOAD_TIMEOUT < 1 || TWC_CYCLES < 1) begin : g_bad_time
      $error("LOAD_TIMEOUT and TWC_CYCLES must be at least 1");
   end

   sfc_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sdp_q, id_q, loaded_q;
   logic [SEC_W-1:0] sec_q;

   logic             wr_cyc, rd_cyc, consumed, plain_wr;
   logic             load_take, load_clear, load_done, commit;
   sfc_cmd_e         cmd;
   logic [SEC_W-1:0] a_sec;
   logic [OFS_W-1:0] a_ofs;
   logic [SECTOR_BYTES*8-1:0] image;
   logic [7:0]       arr_byte;

   assign wr_cyc = ~ce_n & ~we_n & oe_n;
   assign rd_cyc = ~ce_n & ~oe_n & we_n;
   assign a_sec  = addr[OFS_W +: SEC_W];
   assign a_ofs  = addr[OFS_W-1:0];

   sfc_unlock #(.ADDR_W(ADDR_W)) u_unlock (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_cyc && state_q == ST_NORM),
      .addr(addr), .din(din),
      .consumed(consumed), .cmd(cmd)
   );

   assign plain_wr   = wr_cyc && state_q == ST_NORM && !consumed;
   assign load_take  = (wr_cyc && state_q == ST_LOAD && (!loaded_q || a_sec == sec_q))
                     || (plain_wr && !sdp_q);
   assign load_clear = state_q == ST_NORM && wr_cyc && (cmd == CMD_PROG || (plain_wr && !sdp_q));
   assign load_done  = state_q == ST_LOAD && !load_take && cnt_q == CNT_W'(LOAD_TIMEOUT - 1);
   assign commit     = load_done && loaded_q;

   sfc_page_buf #(.SECTOR_BYTES(SECTOR_BYTES)) u_page (
      .clk(clk), .rst_n(rst_n), .clear(load_clear),
      .wr_en(load_take), .ofs(a_ofs), .din(din), .image(image)
   );

   sfc_array #(.SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS)) u_array (
      .clk(clk), .rst_n(rst_n), .commit(commit), .commit_sec(sec_q),
      .image(image), .rd_sec(a_sec), .rd_ofs(a_ofs), .rd_byte(arr_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_NORM;
         cnt_q    <= '0;
         sdp_q    <= 1'b0;
         id_q     <= 1'b0;
         loaded_q <= 1'b0;
         sec_q    <= '0;
      end else begin
         unique case (state_q)
            ST_NORM: if (wr_cyc) begin
               if (cmd == CMD_PROG) begin
                  sdp_q    <= 1'b1;
                  state_q  <= ST_LOAD;
                  cnt_q    <= '0;
                  loaded_q <= 1'b0;
               end else if (cmd == CMD_ID_ENTER || cmd == CMD_ID_EXIT) begin
                  id_q    <= (cmd == CMD_ID_ENTER);
                  state_q <= ST_BUSY;
                  cnt_q   <= CNT_W'(TWC_CYCLES - 1);
               end else if (plain_wr) begin
                  if (sdp_q) begin
                     state_q <= ST_BUSY;
                     cnt_q   <= CNT_W'(TWC_CYCLES - 1);
                  end else begin
                     state_q  <= ST_LOAD;
                     cnt_q    <= '0;
                     loaded_q <= 1'b1;
                     sec_q    <= a_sec;
                  end
               end
            end
            ST_LOAD: begin
               if (load_take) begin
                  cnt_q    <= '0;
                  loaded_q <= 1'b1;
                  sec_q    <= a_sec;
               end else if (load_done) begin
                  state_q <= ST_BUSY;
                  cnt_q   <= CNT_W'(TWC_CYCLES - 1);
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_BUSY: begin
               if (cnt_q == '0) state_q <= ST_NORM;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            default: state_q <= ST_NORM;
         endcase
      end
   end

   always_comb begin
      dout = 8'h00;
      if (rd_cyc) begin
         if (state_q == ST_BUSY)           dout = BUSY_MARK;
         else if (id_q) begin
            if (addr == ADDR_W'(0))         dout = MFR_CODE;
            else if (addr == ADDR_W'(1))    dout = DEV_CODE;
         end else                          dout = arr_byte;
      end
   end

   assign dout_en = rd_cyc;
   assign busy    = (state_q == ST_BUSY);
endmodule

// File: rtl/sfc_checker.sv
`timescale 1ns/1ps
module sfc_checker import sfc_pkg::*; #(
   parameter int         ADDR_W       = 15,
   parameter int         CNT_W        = 5,
   parameter int         LOAD_TIMEOUT = 6,
   parameter int         TWC_CYCLES   = 20,
   parameter logic [7:0] MFR_CODE     = 8'h5A,
   parameter logic [7:0] BUSY_MARK    = 8'hD2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        dout,
   input logic              dout_en,
   input logic              busy,
   input sfc_state_e        state,
   input logic [CNT_W-1:0]  cnt,
   input logic              id_mode
);
   logic rd_c;
   int   busy_run;

   assign rd_c = ~ce_n & ~oe_n & we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_run <= 0;
      else if (!busy) busy_run <= 0;
      else            busy_run <= busy_run + 1;
   end

   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == TWC_CYCLES));

   p_busy_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_c) |-> (dout == BUSY_MARK));

   p_quiet_bus_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_c |-> (!dout_en && dout == 8'h00));

   p_id_mfr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (id_mode && !busy && rd_c && addr == ADDR_W'(0)) |-> (dout == MFR_CODE));

   p_load_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOAD) |-> (cnt < CNT_W'(LOAD_TIMEOUT)));
endmodule

bind sector_flash_ctl sfc_checker #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOAD_TIMEOUT(LOAD_TIMEOUT),
   .TWC_CYCLES(TWC_CYCLES), .MFR_CODE(MFR_CODE), .BUSY_MARK(BUSY_MARK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
   .addr(addr), .dout(dout), .dout_en(dout_en), .busy(busy),
   .state(state_q), .cnt(cnt_q), .id_mode(id_q)
);

// File: tb/sector_flash_ctl_bench.sv
`timescale 1ns/1ps
module sector_flash_ctl_bench;
   localparam int         AW   = 15;
   localparam int         SB   = 8;
   localparam int         NS   = 8;
   localparam int         LT   = 6;
   localparam int         TWC  = 20;
   localparam logic [7:0] MFR  = 8'h5A;
   localparam logic [7:0] DEV  = 8'hC3;
   localparam logic [7:0] MARK = 8'hD2;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = '0;
   logic [7:0]    dout;
   logic          dout_en, busy;

   sector_flash_ctl #(
      .ADDR_W(AW), .SECTOR_BYTES(SB), .NUM_SECTORS(NS), .LOAD_TIMEOUT(LT),
      .TWC_CYCLES(TWC), .MFR_CODE(MFR), .DEV_CODE(DEV), .BUSY_MARK(MARK)
   ) u_sector_flash_ctl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
   );

   always #2 clk = ~clk;

   int         n_chk = 0, n_fail = 0;
   bit         done = 0;
   logic [7:0] model [SB*NS];
   logic [7:0] pg [SB];

   function automatic int idx(logic [AW-1:0] a);
      return int'(a) % (SB*NS);
   endfunction

   function automatic logic [AW-1:0] mk(int sec, int ofs, int hi);
      return AW'(hi*SB*NS + sec*SB + ofs);
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [7:0] v, output logic en);
      ce_n = 1'b0; oe_n = 1'b0; addr = a;
      #1 v = dout; en = dout_en;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic rd_chk(string req, logic [AW-1:0] a, logic [7:0] exp);
      logic [7:0] v;
      logic       en;
      rd(a, v, en);
      check(req, int'(v), int'(exp));
   endtask

   task automatic to_rise(output int n);
      n = 0;
      while (!busy && n < 1000) begin @(negedge clk); n++; end
   endtask

   task automatic run_len(output int n);
      n = 0;
      while (busy && n < 1000) begin @(negedge clk); n++; end
   endtask

   task automatic unlock(logic [7:0] op);
      wr(AW'(16'h5555), 8'hAA);
      wr(AW'(16'h2AAA), 8'h55);
      wr(AW'(16'h5555), op);
   endtask

   task automatic page_reset();
      for (int j = 0; j < SB; j++) pg[j] = 8'hFF;
   endtask

   task automatic page_commit(int s);
      for (int j = 0; j < SB; j++) model[s*SB + j] = pg[j];
   endtask

   task automatic cycle_checks(string req_w, int exp_w);
      int n;
      to_rise(n);
      check(req_w, n, exp_w);
      run_len(n);
      check("R7 busy length", n, TWC);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      logic [7:0] v;
      logic en;
      void'($urandom(32'd2024));
      for (int j = 0; j < SB*NS; j++) model[j] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R13 reset state and quiet bus
      check("R1 busy after reset", int'(busy), 0);
      check("R13 idle dout_en", int'(dout_en), 0);
      check("R13 idle dout", int'(dout), 0);
      rd_chk("R1 erased byte", mk(0, 0, 0), 8'hFF);
      rd_chk("R1 erased byte", mk(7, 7, 3), 8'hFF);
      rd(mk(2, 3, 0), v, en);
      check("R13 dout_en in read", int'(en), 1);

      // R4 R5 R12 random unprotected loads (protection off confirms R1)
      for (int it = 0; it < 8; it++) begin
         int s, cnt;
         s = $urandom_range(NS-1);
         cnt = $urandom_range(SB, 1);
         page_reset();
         for (int k = 0; k < cnt; k++) begin
            int o;
            logic [7:0] d;
            o = $urandom_range(SB-1);
            d = 8'($urandom_range(255));
            if (k == 0 && d == 8'hAA) d = 8'h11;
            wr(mk(s, o, $urandom_range(400)), d);
            pg[o] = d;
         end
         cycle_checks("R4 load window", LT);
         page_commit(s);
         for (int j = 0; j < SB; j++)
            rd_chk("R5 R12 sector readback", mk(s, j, $urandom_range(400)), model[s*SB + j]);
      end

      // R6 other-sector write discarded
      page_reset();
      wr(mk(1, 2, 0), 8'h11); pg[2] = 8'h11;
      wr(mk(4, 2, 0), 8'h22);
      wr(mk(1, 3, 0), 8'h33); pg[3] = 8'h33;
      cycle_checks("R4 load window after discard", LT);
      page_commit(1);
      rd_chk("R6 foreign sector untouched", mk(4, 2, 0), model[4*SB + 2]);
      rd_chk("R6 own sector byte", mk(1, 2, 0), 8'h11);
      rd_chk("R5 unloaded byte FF", mk(1, 0, 0), 8'hFF);

      // R7 marker during busy, write during busy ignored
      page_reset();
      wr(mk(3, 0, 0), 8'h44); pg[0] = 8'h44;
      to_rise(n);
      rd_chk("R7 busy marker", mk(3, 0, 0), MARK);
      wr(mk(6, 1, 0), 8'h99);
      run_len(n);
      page_commit(3);
      n = 0;
      repeat (LT + 2) begin @(negedge clk); n += int'(busy); end
      check("R7 write in busy opened no load", n, 0);
      rd_chk("R7 write in busy not stored", mk(6, 1, 0), model[6*SB + 1]);
      rd_chk("R5 committed byte", mk(3, 0, 0), 8'h44);

      // R2 R3 broken prefix becomes ordinary write
      page_reset();
      wr(AW'(16'h5555), 8'hAA);
      wr(AW'(16'h0010), 8'h12); pg[0] = 8'h12;
      cycle_checks("R3 broken prefix opened load", LT);
      page_commit(2);
      rd_chk("R3 mismatch write stored", AW'(16'h0010), 8'h12);
      rd_chk("R2 prefix byte not stored", AW'(16'h5555), 8'hFF);
      page_reset();
      unlock(8'h77); pg[5] = 8'h77;
      cycle_checks("R3 unknown command opened load", LT);
      page_commit(2);
      rd_chk("R3 unknown command stored", AW'(16'h5555), 8'h77);
      rd_chk("R5 sector rewritten to FF", AW'(16'h0010), 8'hFF);

      // R10 identification mode
      unlock(8'h90);
      check("R10 busy after enter", int'(busy), 1);
      run_len(n);
      check("R7 busy length id enter", n, TWC);
      rd_chk("R10 maker code", AW'(0), MFR);
      rd_chk("R10 device code", AW'(1), DEV);
      rd_chk("R10 other addr", AW'(2), 8'h00);
      rd_chk("R10 no mirror", mk(0, 0, 1), 8'h00);

      // R11 leave identification mode
      unlock(8'hF0);
      check("R11 busy after exit", int'(busy), 1);
      run_len(n);
      check("R7 busy length id exit", n, TWC);
      rd_chk("R11 array back", AW'(16'h5555), 8'h77);
      rd_chk("R11 array addr0", AW'(0), model[0]);

      // R8 protected load
      page_reset();
      unlock(8'hA0);
      wr(mk(5, 7, 0), 8'h5C); pg[7] = 8'h5C;
      wr(mk(5, 1, 0), 8'h01); pg[1] = 8'h01;
      cycle_checks("R8 protected load window", LT);
      page_commit(5);
      rd_chk("R8 protected load stored", mk(5, 7, 0), 8'h5C);
      rd_chk("R8 unloaded FF", mk(5, 0, 0), 8'hFF);

      // R9 unprotected write rejected
      wr(mk(5, 7, 0), 8'h0F);
      check("R9 busy at once", int'(busy), 1);
      run_len(n);
      check("R9 busy length", n, TWC);
      rd_chk("R9 nothing stored", mk(5, 7, 0), 8'h5C);
      wr(AW'(16'h5555), 8'hAA);
      wr(AW'(0), 8'h33);
      check("R3 R9 broken prefix protected", int'(busy), 1);
      run_len(n);
      rd_chk("R9 broken prefix not stored", AW'(0), model[0]);

      // R8 protection persists, empty window
      page_reset();
      unlock(8'hA0);
      wr(mk(5, 7, 0), 8'h02); pg[7] = 8'h02;
      cycle_checks("R8 second protected load", LT);
      page_commit(5);
      rd_chk("R8 second load stored", mk(5, 7, 0), 8'h02);
      unlock(8'hA0);
      cycle_checks("R8 empty window", LT);
      rd_chk("R8 empty window stores nothing", mk(5, 7, 0), 8'h02);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule